// File: doc/BRIEF.md
# Key-Protected Interrupt and Reset Control Register

This block is one 32-bit control register inside an interrupt and reset controller. Software reaches it over a simple synchronous register bus made of a select, a write enable, write data and combinational read data. A write lands only when the upper half of the write data carries the unlock key 0x05FA. Any write without that key is dropped as a whole. A read always shows the fixed signature 0xFA05 in the upper half, so software can never read the key back.

The register stores two things: an endianness indicator and a 3-bit priority-grouping field. The grouping field is decoded into an 8-bit mask that marks which bits of an 8-bit interrupt priority are pre-emption bits; the remaining bits are subpriority bits. The register also drives three action outputs:

- a sticky system reset request, which only a warm reset clears;
- a one-cycle strobe that clears the active interrupt state;
- a one-cycle local reset pulse for the core, which leaves the debug domain untouched.

Power-on reset clears everything. Warm reset clears only the request and the strobes.

Top module: `kprc_ctrl_reg`

## Requirements
- R1: After power-on reset (`rst` high for a clock edge), a selected read returns 0xFA050000. All three action outputs are 0 and `preempt_mask` is 8'hFE.
- R2: A write is accepted at a rising edge only when `sel` and `wr_en` are both high and `wdata[31:16]` equals 16'h05FA. Any other key leaves every field and output unchanged.
- R3: `rdata[31:16]` reads 16'hFA05 whenever `sel` is high, whatever key was written. `rdata` is all zeros when `sel` is low.
- R4: Bit 15 is the endianness indicator (1 means big endian). An accepted write stores it, it reads back in bit 15, and it drives `big_endian`.
- R5: Bits 14:11 and 7:3 always read 0, and writing them has no effect.
- R6: Bits 10:8 hold the grouping field g, which reads back in bits 10:8 and on `prio_group`. `preempt_mask` is 8'hFF shifted left by g+1, truncated to 8 bits, so it holds 7−g ones and is 0 for g=7.
- R7: An accepted write with bit 2 set raises `sys_reset_req` after that edge. The request reads back in bit 2 and stays high until a warm reset, even through later writes of 0.
- R8: An accepted write with bit 1 set makes `clr_active_pulse` high for exactly the cycle after that edge. Bit 1 always reads 0.
- R9: An accepted write with bit 0 set makes `core_reset_pulse` high for exactly the cycle after that edge. Bit 0 always reads 0.
- R10: `warm_rst` high at an edge clears `sys_reset_req` and both strobes. The endianness and grouping fields are kept.
- R11: An accepted write that sets both bit 2 and bit 0 raises `sys_reset_req` and `core_reset_pulse` in the same cycle.
- R12: When `warm_rst` and an accepted write meet at the same edge, the action outputs stay 0, while the endianness and grouping fields still take the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rst | input | 1 | Power-on reset, synchronous, active high |
| warm_rst | input | 1 | Warm reset, synchronous, active high |
| sel | input | 1 | Register select from the bus |
| wr_en | input | 1 | Write enable from the bus |
| wdata | input | 32 | Write data including the unlock key |
| rdata | output | 32 | Combinational read data |
| big_endian | output | 1 | Stored endianness indicator |
| prio_group | output | 3 | Stored priority-grouping field |
| preempt_mask | output | 8 | 1 marks a pre-emption bit of the priority |
| sys_reset_req | output | 1 | Sticky system reset request |
| clr_active_pulse | output | 1 | One-cycle clear-active-state strobe |
| core_reset_pulse | output | 1 | One-cycle local core reset pulse |

## Verification
A wrongly accepted keyless write shows up on the very next read as a changed endianness bit, grouping field or mask. It can also show up one cycle after the edge as a spurious strobe or request. A strobe held too long is visible on the second cycle after the write, and a request cleared too early is visible on the cycle after an unrelated write. The bench therefore compares every output and a full read against a bench model after each edge, with no delay. Warm reset is interleaved at random with valid and invalid writes, so that it is exercised both alone and colliding with writes.

// File: rtl/kprc_pkg.sv
package kprc_pkg;

    localparam int DATA_W   = 32;
    localparam int KEY_W    = 16;
    localparam int PRIO_W   = 8;
    localparam int GRP_W    = $clog2(PRIO_W);

    localparam logic [KEY_W-1:0] WR_KEY = 16'h05FA;
    localparam logic [KEY_W-1:0] RD_SIG = 16'hFA05;

    // Bit positions decoded by the neighbouring interrupt and reset logic
    localparam int ENDIAN_BIT = 15;
    localparam int GRP_LSB    = 8;
    localparam int REQ_BIT    = 2;
    localparam int CLR_BIT    = 1;
    localparam int LRST_BIT   = 0;

    localparam logic [DATA_W-1:0] RSV_MASK = 32'h0000_78F8;

    typedef struct packed {
        logic             big_endian;
        logic [GRP_W-1:0] group;
    } cfg_t;

    typedef struct packed {
        logic sys_req;
        logic clr_active;
        logic core_rst;
    } act_t;

    function automatic logic [KEY_W-1:0] key_of(input logic [DATA_W-1:0] d);
        return d[DATA_W-1 -: KEY_W];
    endfunction

    function automatic cfg_t cfg_of(input logic [DATA_W-1:0] d);
        cfg_t c;
        c.big_endian = d[ENDIAN_BIT];
        c.group      = d[GRP_LSB +: GRP_W];
        return c;
    endfunction

    function automatic act_t act_of(input logic [DATA_W-1:0] d);
        act_t a;
        a.sys_req    = d[REQ_BIT];
        a.clr_active = d[CLR_BIT];
        a.core_rst   = d[LRST_BIT];
        return a;
    endfunction

    function automatic logic [DATA_W-1:0] pack_read(input cfg_t c, input logic req);
        logic [DATA_W-1:0] r;
        r                      = '0;
        r[DATA_W-1 -: KEY_W]   = RD_SIG;
        r[ENDIAN_BIT]          = c.big_endian;
        r[GRP_LSB +: GRP_W]    = c.group;
        r[REQ_BIT]             = req;
        return r;
    endfunction

endpackage

// File: rtl/kprc_write_gate.sv
module kprc_write_gate
    import kprc_pkg::*;
(
    input  logic              sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              accept,
    output cfg_t              wcfg,
    output act_t              wact
);
    logic key_ok;
    logic unused_rsv;

    assign key_ok     = (key_of(wdata) == WR_KEY);
    assign accept     = sel & wr_en & key_ok;
    assign wcfg       = cfg_of(wdata);
    assign wact       = act_of(wdata);
    assign unused_rsv = ^{wdata[14:11], wdata[7:3]};

endmodule

// File: rtl/kprc_cfg_store.sv
module kprc_cfg_store
    import kprc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  cfg_t wcfg,
    output cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (accept) begin
            cfg_q <= wcfg;
        end
    end

    // R2: a rejected or absent write leaves the configuration untouched
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(cfg_q));

endmodule

// File: rtl/kprc_action_unit.sv
module kprc_action_unit
    import kprc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic warm_rst,
    input  logic accept,
    input  act_t wact,
    output act_t act_q
);
    act_t act_d;

    always_comb begin
        act_d            = act_q;
        act_d.clr_active = 1'b0;
        act_d.core_rst   = 1'b0;
        if (warm_rst) begin
            act_d.sys_req = 1'b0;
        end else if (accept) begin
            act_d.sys_req    = act_q.sys_req | wact.sys_req;
            act_d.clr_active = wact.clr_active;
            act_d.core_rst   = wact.core_rst;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else begin
            act_q <= act_d;
        end
    end

    // R7: the request is sticky until warm reset
    p_req_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (act_q.sys_req && !warm_rst) |=> act_q.sys_req);

    // R8: a clear strobe only follows an accepted write of bit 1
    p_clr_origin_r8: assert property (@(posedge clk) disable iff (rst)
        act_q.clr_active |-> $past(accept && wact.clr_active && !warm_rst));

    // R9: a core pulse only follows an accepted write of bit 0
    p_lrst_origin_r9: assert property (@(posedge clk) disable iff (rst)
        act_q.core_rst |-> $past(accept && wact.core_rst && !warm_rst));

    // R10: warm reset clears every action output
    p_warm_clear_r10: assert property (@(posedge clk) disable iff (rst)
        warm_rst |=> (act_q == '0));

    // R11: request and core pulse rise together on a combined write
    p_joint_r11: assert property (@(posedge clk) disable iff (rst)
        (accept && !warm_rst && wact.sys_req && wact.core_rst)
            |=> (act_q.sys_req && act_q.core_rst));

endmodule

// File: rtl/kprc_mask_decode.sv
module kprc_mask_decode #(
    parameter int PRIO_W = 8,
    localparam int GRP_W = $clog2(PRIO_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GRP_W-1:0]  group,
    output logic [PRIO_W-1:0] mask
);
    // Position i is pre-emption when it lies above the g+1 subpriority bits
    for (genvar i = 0; i < PRIO_W; i++) begin : g_bit
        assign mask[i] = (i > int'(group));
    end

    // R6: number of pre-emption bits is PRIO_W-1-g
    p_mask_count_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(mask) == (PRIO_W - 1 - int'(group)));

    // R6: no bit of the mask below the top g+1 positions... lowest bit is always subpriority
    p_mask_lsb_r6: assert property (@(posedge clk) disable iff (rst)
        !mask[0]);

endmodule

// File: rtl/kprc_ctrl_reg.sv
module kprc_ctrl_reg
    import kprc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              warm_rst,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              big_endian,
    output logic [2:0]        prio_group,
    output logic [7:0]        preempt_mask,
    output logic              sys_reset_req,
    output logic              clr_active_pulse,
    output logic              core_reset_pulse
);
    logic accept;
    cfg_t wcfg;
    act_t wact;
    cfg_t cfg_q;
    act_t act_q;

    kprc_write_gate u_gate (
        .sel    (sel),
        .wr_en  (wr_en),
        .wdata  (wdata),
        .accept (accept),
        .wcfg   (wcfg),
        .wact   (wact)
    );

    kprc_cfg_store u_cfg (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .wcfg   (wcfg),
        .cfg_q  (cfg_q)
    );

    kprc_action_unit u_act (
        .clk      (clk),
        .rst      (rst),
        .warm_rst (warm_rst),
        .accept   (accept),
        .wact     (wact),
        .act_q    (act_q)
    );

    kprc_mask_decode #(.PRIO_W(PRIO_W)) u_mask (
        .clk   (clk),
        .rst   (rst),
        .group (cfg_q.group),
        .mask  (preempt_mask)
    );

    assign rdata            = sel ? pack_read(cfg_q, act_q.sys_req) : '0;
    assign big_endian       = cfg_q.big_endian;
    assign prio_group       = cfg_q.group;
    assign sys_reset_req    = act_q.sys_req;
    assign clr_active_pulse = act_q.clr_active;
    assign core_reset_pulse = act_q.core_rst;

    // R5: reserved bits never appear on the read bus
    p_rsv_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (rdata & RSV_MASK) == '0);

    // R3: the key is never echoed, the signature always is
    p_sig_r3: assert property (@(posedge clk) disable iff (rst)
        sel |-> (rdata[31:16] == RD_SIG));

    // R8/R9: self-clearing bits read back as zero
    p_selfclr_rd_r8: assert property (@(posedge clk) disable iff (rst)
        rdata[1:0] == 2'b00);

endmodule

// File: tb/kprc_ctrl_reg_tb.sv
module kprc_ctrl_reg_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        warm_rst = 1'b0;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        big_endian;
    logic [2:0]  prio_group;
    logic [7:0]  preempt_mask;
    logic        sys_reset_req;
    logic        clr_active_pulse;
    logic        core_reset_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    // bench model
    logic       m_endian = 1'b0;
    logic [2:0] m_group  = 3'd0;
    logic       m_req    = 1'b0;
    logic       m_clr    = 1'b0;
    logic       m_lrst   = 1'b0;

    kprc_ctrl_reg u_dut (
        .clk              (clk),
        .rst              (rst),
        .warm_rst         (warm_rst),
        .sel              (sel),
        .wr_en            (wr_en),
        .wdata            (wdata),
        .rdata            (rdata),
        .big_endian       (big_endian),
        .prio_group       (prio_group),
        .preempt_mask     (preempt_mask),
        .sys_reset_req    (sys_reset_req),
        .clr_active_pulse (clr_active_pulse),
        .core_reset_pulse (core_reset_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] exp_mask(input logic [2:0] g);
        logic [7:0] m;
        for (int i = 0; i < 8; i++) m[i] = (i > int'(g));
        return m;
    endfunction

    function automatic logic [31:0] exp_read();
        logic [31:0] r;
        r = 32'hFA05_0000;
        r[15] = m_endian;
        r[10:8] = m_group;
        r[2] = m_req;
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " R3 read"}, rdata, exp_read());
        check({tag, " R4 endian"}, 32'(big_endian), 32'(m_endian));
        check({tag, " R6 group"}, 32'(prio_group), 32'(m_group));
        check({tag, " R6 mask"}, 32'(preempt_mask), 32'(exp_mask(m_group)));
        check({tag, " R7 req"}, 32'(sys_reset_req), 32'(m_req));
        check({tag, " R8 clr"}, 32'(clr_active_pulse), 32'(m_clr));
        check({tag, " R9 lrst"}, 32'(core_reset_pulse), 32'(m_lrst));
    endtask

    // one bus cycle: drive at negedge, edge, then read back with sel high
    task automatic cycle(input logic s, input logic w, input logic [31:0] d,
                         input logic warm, input string tag);
        logic acc;
        @(negedge clk);
        sel = s; wr_en = w; wdata = d; warm_rst = warm;
        acc = s && w && (d[31:16] == 16'h05FA);
        @(posedge clk);
        m_clr = 1'b0;
        m_lrst = 1'b0;
        if (acc) begin
            m_endian = d[15];
            m_group  = d[10:8];
        end
        if (warm) begin
            m_req = 1'b0;
        end else if (acc) begin
            m_req  = m_req | d[2];
            m_clr  = d[1];
            m_lrst = d[0];
        end
        #1;
        sel = 1'b1; wr_en = 1'b0; warm_rst = 1'b0;
        #1;
        check_all(tag);
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        sel = 1'b1;
        #1;
        // R1: reset state
        check("R1 reset read", rdata, 32'hFA05_0000);
        check("R1 reset mask", 32'(preempt_mask), 32'h0000_00FE);
        check("R1 reset actions", {29'd0, sys_reset_req, clr_active_pulse, core_reset_pulse}, 32'd0);

        // R3: deselected read is zero
        sel = 1'b0;
        #1;
        check("R3 deselected", rdata, 32'd0);

        // R2: bad key writes ignored
        cycle(1'b1, 1'b1, 32'h05FB_87FF, 1'b0, "R2 badkey");
        cycle(1'b1, 1'b1, 32'hFA05_87FF, 1'b0, "R2 sigkey");
        cycle(1'b0, 1'b1, 32'h05FA_87FF, 1'b0, "R2 nosel");
        cycle(1'b1, 1'b0, 32'h05FA_87FF, 1'b0, "R2 nowr");

        // R5: reserved bits written are not stored
        cycle(1'b1, 1'b1, 32'h05FA_78F8, 1'b0, "R5 rsv");
        check("R5 rsv zero", rdata & 32'h0000_78F8, 32'd0);

        // R6: all grouping values
        for (int g = 0; g < 8; g++) begin
            cycle(1'b1, 1'b1, 32'h05FA_0000 | (32'(g) << 8) | 32'h8000, 1'b0, "R6 sweep");
        end
        check("R6 g7 mask zero", 32'(preempt_mask), 32'd0);

        // R8/R9: pulses last one cycle
        cycle(1'b1, 1'b1, 32'h05FA_0003, 1'b0, "R8 R9 strobe");
        cycle(1'b0, 1'b0, 32'h0, 1'b0, "R8 R9 strobe gone");

        // R11 and R7: joint, then sticky through a zero write
        cycle(1'b1, 1'b1, 32'h05FA_0005, 1'b0, "R11 joint");
        cycle(1'b1, 1'b1, 32'h05FA_0300, 1'b0, "R7 sticky");

        // R10: warm reset keeps fields
        cycle(1'b0, 1'b0, 32'h0, 1'b1, "R10 warm");
        check("R10 fields kept", 32'(prio_group), 32'd3);

        // R12: warm collides with write
        cycle(1'b1, 1'b1, 32'h05FA_8507, 1'b1, "R12 collide");
        check("R12 no action", {29'd0, sys_reset_req, clr_active_pulse, core_reset_pulse}, 32'd0);

        // random mix
        for (int k = 0; k < 400; k++) begin
            d = $urandom();
            if ($urandom_range(0, 9) < 6) d[31:16] = 16'h05FA;
            cycle($urandom_range(0, 9) != 0, $urandom_range(0, 9) != 0, d,
                  $urandom_range(0, 9) == 0, "R2 R4 R7 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule